// File: doc/BRIEF.md
# Vector Operation Performance Counter

This block observes a stream of retired vector-operation events and keeps three running totals: how many operations were recorded, how many lanes did useful work, and how many cycles of simulated latency were charged. Each event carries a 5-bit operation class and a lane-enable mask. The class selects a fixed latency from a built-in table. Masked classes add the population count of the mask to the lane total. Unmasked classes add the full lane width whatever the mask holds.

A synchronous clear zeroes the three totals. A small read port selects one total at a time by a 2-bit address, so a host can compute throughput ratios off-block. An event with an undefined class code is dropped. It moves a two-state controller from `CLEAN` to `FAULT`, and that state drives a sticky error output. The controller's only transitions are `CLEAN -> FAULT` on an undefined-class event when no clear is present, and `FAULT -> CLEAN` on reset only. Clear does not leave `FAULT`.

Top module: `vpc_perf_counter`

## Requirements
- R1: Each accepted event with a defined, recording class (codes 1..14) adds exactly one to the operation total on the next clock edge.
- R2: The latency total grows by the class latency: 1 load=7, 2 store=4, 3 explicit set=1, 4 masked broadcast=3, 5 integer add/sub/abs/min/max=1, 6 integer multiply=3, 7 integer divide=20, 8 float add/sub/mul=4, 9 float abs/min/max=1, 10 float divide=11, 11 float square root=14, 12 horizontal add/interleave=5, 13 compare=3, 14 mask op=1.
- R3: For masked classes (every recording class except 3 and 14), the lane total grows by the number of set bits in `ev_mask_i`, where bit i enables lane i.
- R4: For the unmasked classes 3 and 14, the lane total grows by LANES (4) regardless of the mask.
- R5: Class 0 (all-true mask constant) changes no total and does not set the error flag.
- R6: `clr_i` high zeroes all three totals on the next edge, and an event in the same cycle is dropped.
- R7: A valid event with class code 15..31 changes no total and sets `err_o`, which stays high through later clears until reset.
- R8: Totals are CNT_W bits wide and wrap modulo 2^CNT_W with no indication.
- R9: `rd_data_o` returns, combinationally, the operation total for `rd_addr_i`=0, the lane total for 1, the latency total for 2, and zero for 3.
- R10: After reset all totals read zero and `err_o` is low.
- R11: With `ev_valid_i` low, class and mask inputs have no effect on any total or on `err_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr_i | input | 1 | Synchronous clear of all totals |
| ev_valid_i | input | 1 | Event present this cycle |
| ev_class_i | input | 5 | Operation class code |
| ev_mask_i | input | LANES (4) | Lane-enable mask, bit i = lane i |
| rd_addr_i | input | 2 | Total select for the read port |
| rd_data_o | output | CNT_W (64) | Selected total |
| err_o | output | 1 | Sticky undefined-class flag |

## Verification
A table of events is walked with every class code, once each. The masks vary across the table, including all-clear, single-bit and full patterns. This separates a wrong latency entry from a wrong lane rule, and a masked class from an unmasked one. The unmasked classes are given masks with zero or one bit set, so counting the mask in place of LANES gives a visible difference. Directed cases cover the following: class 0 against an undefined code, where only the second raises the flag; clear together with an event, to prove that clear wins; and events sent with valid low. A narrow-width second instance is driven past its modulus to show the silent wrap.

// File: rtl/vpc_pkg.sv
package vpc_pkg;

    localparam int CLS_W = 5;
    localparam int LAT_W = 5;

    typedef enum logic [CLS_W-1:0] {
        CLS_ALLTRUE = 5'd0,
        CLS_LOAD    = 5'd1,
        CLS_STORE   = 5'd2,
        CLS_SET     = 5'd3,
        CLS_BCAST   = 5'd4,
        CLS_IALU    = 5'd5,
        CLS_IMUL    = 5'd6,
        CLS_IDIV    = 5'd7,
        CLS_FARITH  = 5'd8,
        CLS_FSIMPLE = 5'd9,
        CLS_FDIV    = 5'd10,
        CLS_FSQRT   = 5'd11,
        CLS_SHUF    = 5'd12,
        CLS_CMP     = 5'd13,
        CLS_MASKOP  = 5'd14
    } vpc_cls_e;

    typedef struct packed {
        logic             known;
        logic             records;
        logic             masked;
        logic [LAT_W-1:0] latency;
    } vpc_cls_info_t;

    typedef enum logic [0:0] {
        ST_CLEAN = 1'b0,
        ST_FAULT = 1'b1
    } vpc_state_e;

endpackage

// File: rtl/vpc_class_decode.sv
module vpc_class_decode
    import vpc_pkg::*;
(
    input  logic [CLS_W-1:0] cls_i,
    output vpc_cls_info_t    info_o
);

    // Fixed per-class charge: instruction latency, not issue throughput.
    always_comb begin
        info_o = '{known: 1'b1, records: 1'b1, masked: 1'b1, latency: '0};
        unique case (cls_i)
            CLS_ALLTRUE: begin
                info_o.records = 1'b0;
                info_o.latency = LAT_W'(0);
            end
            CLS_LOAD:    info_o.latency = LAT_W'(7);
            CLS_STORE:   info_o.latency = LAT_W'(4);
            CLS_SET: begin
                info_o.masked  = 1'b0;
                info_o.latency = LAT_W'(1);
            end
            CLS_BCAST:   info_o.latency = LAT_W'(3);
            CLS_IALU:    info_o.latency = LAT_W'(1);
            CLS_IMUL:    info_o.latency = LAT_W'(3);
            CLS_IDIV:    info_o.latency = LAT_W'(20);
            CLS_FARITH:  info_o.latency = LAT_W'(4);
            CLS_FSIMPLE: info_o.latency = LAT_W'(1);
            CLS_FDIV:    info_o.latency = LAT_W'(11);
            CLS_FSQRT:   info_o.latency = LAT_W'(14);
            CLS_SHUF:    info_o.latency = LAT_W'(5);
            CLS_CMP:     info_o.latency = LAT_W'(3);
            CLS_MASKOP: begin
                info_o.masked  = 1'b0;
                info_o.latency = LAT_W'(1);
            end
            default: begin
                info_o.known   = 1'b0;
                info_o.records = 1'b0;
                info_o.latency = LAT_W'(0);
            end
        endcase
    end

endmodule

// File: rtl/vpc_lane_count.sv
module vpc_lane_count #(
    parameter int LANES = 4,
    localparam int CW   = $clog2(LANES + 1)
) (
    input  logic [LANES-1:0] mask_i,
    input  logic             masked_i,
    output logic [CW-1:0]    lanes_o
);

    logic [CW-1:0] partial [LANES+1];

    assign partial[0] = '0;

    generate
        for (genvar g = 0; g < LANES; g++) begin : g_pop
            assign partial[g+1] = partial[g] + CW'(mask_i[g]);
        end
    endgenerate

    assign lanes_o = masked_i ? partial[LANES] : CW'(LANES);

endmodule

// File: rtl/vpc_accum.sv
module vpc_accum #(
    parameter int W     = 64,
    parameter int INC_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             en_i,
    input  logic [INC_W-1:0] inc_i,
    output logic [W-1:0]     total_o
);

    // Modular add: overflow wraps with no flag.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            total_o <= '0;
        end else if (clr_i) begin
            total_o <= '0;
        end else if (en_i) begin
            total_o <= total_o + W'(inc_i);
        end
    end

endmodule

// File: rtl/vpc_perf_counter.sv
module vpc_perf_counter
    import vpc_pkg::*;
#(
    parameter int LANES = 4,
    parameter int CNT_W = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             ev_valid_i,
    input  logic [4:0]       ev_class_i,
    input  logic [LANES-1:0] ev_mask_i,
    input  logic [1:0]       rd_addr_i,
    output logic [CNT_W-1:0] rd_data_o,
    output logic             err_o
);

    localparam int LCNT_W = $clog2(LANES + 1);

    vpc_cls_info_t     info;
    logic [LCNT_W-1:0] lane_inc;
    logic              take;
    logic              bad_evt;
    logic [CNT_W-1:0]  instr_total;
    logic [CNT_W-1:0]  lane_total;
    logic [CNT_W-1:0]  lat_total;
    vpc_state_e        state_q;
    vpc_state_e        state_d;

    vpc_class_decode u_dec (
        .cls_i  (ev_class_i),
        .info_o (info)
    );

    vpc_lane_count #(.LANES(LANES)) u_pop (
        .mask_i   (ev_mask_i),
        .masked_i (info.masked),
        .lanes_o  (lane_inc)
    );

    // Clear outranks any same-cycle event.
    assign take    = ev_valid_i && !clr_i && info.known && info.records;
    assign bad_evt = ev_valid_i && !clr_i && !info.known;

    vpc_accum #(.W(CNT_W), .INC_W(1)) u_instr (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (clr_i),
        .en_i    (take),
        .inc_i   (1'b1),
        .total_o (instr_total)
    );

    vpc_accum #(.W(CNT_W), .INC_W(LCNT_W)) u_lanes (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (clr_i),
        .en_i    (take),
        .inc_i   (lane_inc),
        .total_o (lane_total)
    );

    vpc_accum #(.W(CNT_W), .INC_W(LAT_W)) u_lat (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (clr_i),
        .en_i    (take),
        .inc_i   (info.latency),
        .total_o (lat_total)
    );

    // Fault controller: state register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_CLEAN;
        end else begin
            state_q <= state_d;
        end
    end

    // Fault controller: next state and outputs.
    always_comb begin
        state_d = state_q;
        err_o   = 1'b0;
        unique case (state_q)
            ST_CLEAN: begin
                if (bad_evt) begin
                    state_d = ST_FAULT;
                end
            end
            ST_FAULT: begin
                err_o = 1'b1;
            end
            default: begin
                state_d = ST_CLEAN;
            end
        endcase
    end

    always_comb begin
        unique case (rd_addr_i)
            2'd0:    rd_data_o = instr_total;
            2'd1:    rd_data_o = lane_total;
            2'd2:    rd_data_o = lat_total;
            default: rd_data_o = '0;
        endcase
    end

endmodule

// File: rtl/vpc_perf_counter_chk.sv
module vpc_perf_counter_chk #(
    parameter int LANES = 4,
    parameter int CNT_W = 64
) (
    input logic             clk,
    input logic             rst_n,
    input logic             clr_i,
    input logic             ev_valid_i,
    input logic [4:0]       ev_class_i,
    input logic             err_o,
    input logic [CNT_W-1:0] instr_q,
    input logic [CNT_W-1:0] lanes_q,
    input logic [CNT_W-1:0] lat_q
);

    assert_clear_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (instr_q == '0) && (lanes_q == '0) && (lat_q == '0));

    assert_instr_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i && ev_valid_i && ev_class_i >= 5'd1 && ev_class_i <= 5'd14)
        |=> instr_q == $past(instr_q) + CNT_W'(1));

    assert_idle_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i && !ev_valid_i)
        |=> $stable(instr_q) && $stable(lanes_q) && $stable(lat_q) && $stable(err_o));

    assert_zero_class_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i && ev_valid_i && ev_class_i == 5'd0)
        |=> $stable(instr_q) && $stable(lanes_q) && $stable(lat_q));

    assert_bad_nocount_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i && ev_valid_i && ev_class_i > 5'd14)
        |=> $stable(instr_q) && $stable(lanes_q) && err_o);

    assert_err_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |=> err_o);

    assert_lane_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_i |=> (lanes_q - $past(lanes_q)) <= CNT_W'(LANES));

endmodule

bind vpc_perf_counter vpc_perf_counter_chk #(.LANES(LANES), .CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr_i      (clr_i),
    .ev_valid_i (ev_valid_i),
    .ev_class_i (ev_class_i),
    .err_o      (err_o),
    .instr_q    (instr_total),
    .lanes_q    (lane_total),
    .lat_q      (lat_total)
);

// File: tb/vpc_perf_counter_bench.sv
module vpc_perf_counter_bench;

    localparam int LANES = 4;
    localparam int CNT_W = 64;
    localparam int NW    = 8;

    typedef struct packed {
        logic [4:0]  cls;
        logic [3:0]  mask;
        logic [7:0]  d_lat;
        logic [3:0]  d_lanes;
        logic [1:0]  d_instr;
    } vec_t;

    localparam int NVEC = 16;
    localparam vec_t VECS [NVEC] = '{
        '{5'd1,  4'b0011, 8'd7,  4'd2, 2'd1},  // R2 R3 load
        '{5'd2,  4'b1111, 8'd4,  4'd4, 2'd1},  // store
        '{5'd3,  4'b0000, 8'd1,  4'd4, 2'd1},  // R4 set, empty mask
        '{5'd4,  4'b0101, 8'd3,  4'd2, 2'd1},
        '{5'd5,  4'b1000, 8'd1,  4'd1, 2'd1},
        '{5'd6,  4'b0110, 8'd3,  4'd2, 2'd1},
        '{5'd7,  4'b1110, 8'd20, 4'd3, 2'd1},
        '{5'd8,  4'b0001, 8'd4,  4'd1, 2'd1},
        '{5'd9,  4'b1011, 8'd1,  4'd3, 2'd1},
        '{5'd10, 4'b0000, 8'd11, 4'd0, 2'd1},
        '{5'd11, 4'b0111, 8'd14, 4'd3, 2'd1},
        '{5'd12, 4'b1100, 8'd5,  4'd2, 2'd1},
        '{5'd13, 4'b1111, 8'd3,  4'd4, 2'd1},
        '{5'd14, 4'b0010, 8'd1,  4'd4, 2'd1},  // R4 mask op, one bit
        '{5'd0,  4'b1111, 8'd0,  4'd0, 2'd0},  // R5 class 0
        '{5'd20, 4'b1111, 8'd0,  4'd0, 2'd0}   // R7 undefined
    };

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             clr = 1'b0;
    logic             valid = 1'b0;
    logic [4:0]       cls = '0;
    logic [3:0]       mask = '0;
    logic [1:0]       addr = '0;
    logic [CNT_W-1:0] rdata;
    logic             err;

    logic             n_clr = 1'b0;
    logic             n_valid = 1'b0;
    logic [4:0]       n_cls = '0;
    logic [3:0]       n_mask = '0;
    logic [1:0]       n_addr = '0;
    logic [NW-1:0]    n_rdata;
    logic             n_err;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    vpc_perf_counter #(.LANES(LANES), .CNT_W(CNT_W)) u_vpc_perf_counter (
        .clk (clk), .rst_n (rst_n), .clr_i (clr), .ev_valid_i (valid),
        .ev_class_i (cls), .ev_mask_i (mask), .rd_addr_i (addr),
        .rd_data_o (rdata), .err_o (err)
    );

    vpc_perf_counter #(.LANES(LANES), .CNT_W(NW)) u_vpc_perf_counter_narrow (
        .clk (clk), .rst_n (rst_n), .clr_i (n_clr), .ev_valid_i (n_valid),
        .ev_class_i (n_cls), .ev_mask_i (n_mask), .rd_addr_i (n_addr),
        .rd_data_o (n_rdata), .err_o (n_err)
    );

    task automatic chk(input string req, input logic [CNT_W-1:0] act, input logic [CNT_W-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic rd(input logic [1:0] a, output logic [CNT_W-1:0] v);
        addr = a;
        #1;
        v = rdata;
    endtask

    task automatic event1(input logic [4:0] c, input logic [3:0] m, input logic cl);
        @(negedge clk);
        valid = 1'b1; cls = c; mask = m; clr = cl;
        @(negedge clk);
        valid = 1'b0; clr = 1'b0;
    endtask

    task automatic chk_all(input string req, input logic [CNT_W-1:0] ei,
                           input logic [CNT_W-1:0] el, input logic [CNT_W-1:0] et);
        logic [CNT_W-1:0] v;
        rd(2'd0, v); chk({req, " instr"}, v, ei);
        rd(2'd1, v); chk({req, " lanes"}, v, el);
        rd(2'd2, v); chk({req, " latency"}, v, et);
    endtask

    initial begin
        logic [CNT_W-1:0] ei, el, et, v;
        ei = '0; el = '0; et = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R10 reset state
        chk_all("R10", '0, '0, '0);
        chk("R10 err", {63'd0, err}, '0);

        // Table walk: R1 R2 R3 R4 R5 R7
        for (int i = 0; i < NVEC; i++) begin
            event1(VECS[i].cls, VECS[i].mask, 1'b0);
            ei += CNT_W'(VECS[i].d_instr);
            el += CNT_W'(VECS[i].d_lanes);
            et += CNT_W'(VECS[i].d_lat);
            rd(2'd0, v); chk("R1 instr", v, ei);
            rd(2'd1, v); chk("R3 or R4 lanes", v, el);
            rd(2'd2, v); chk("R2 latency", v, et);
            chk("R7 err after table entry", {63'd0, err}, (VECS[i].cls > 5'd14) ? 1 : 0);
        end

        // R9 address 3 reads zero
        rd(2'd3, v); chk("R9 addr3", v, '0);

        // R11 valid low: inputs ignored
        @(negedge clk);
        cls = 5'd7; mask = 4'hF; valid = 1'b0;
        repeat (2) @(negedge clk);
        cls = 5'd25;
        @(negedge clk);
        chk_all("R11", ei, el, et);

        // R6 clear; R7 flag survives it
        @(negedge clk); clr = 1'b1;
        @(negedge clk); clr = 1'b0;
        ei = '0; el = '0; et = '0;
        chk_all("R6 clear", ei, el, et);
        chk("R7 sticky through clear", {63'd0, err}, 1);

        // R6 clear with same-cycle event
        event1(5'd2, 4'b1111, 1'b0);
        chk_all("R1 post clear", 1, 4, 4);
        event1(5'd7, 4'b1111, 1'b1);
        chk_all("R6 clear wins", '0, '0, '0);

        // R5 class 0 leaves flag on fresh reset
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        chk("R10 err after reset", {63'd0, err}, 0);
        event1(5'd0, 4'b1111, 1'b0);
        chk_all("R5", '0, '0, '0);
        chk("R5 err", {63'd0, err}, 0);
        event1(5'd31, 4'b0000, 1'b0);
        chk("R7 code 31", {63'd0, err}, 1);

        // R8 wrap on the narrow instance: 13 divides, 260 -> 4, 52 lanes
        for (int k = 0; k < 13; k++) begin
            @(negedge clk);
            n_valid = 1'b1; n_cls = 5'd7; n_mask = 4'hF;
        end
        @(negedge clk);
        n_valid = 1'b0;
        n_addr = 2'd2; #1; chk("R8 wrap latency", CNT_W'(n_rdata), 4);
        n_addr = 2'd0; #1; chk("R8 instr", CNT_W'(n_rdata), 13);
        n_addr = 2'd1; #1; chk("R8 lanes", CNT_W'(n_rdata), 52);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

endmodule